// File: doc/BRIEF.md
# Pixel Output Formatting Pipeline

This block sits between a sample converter and the output pads of an imaging front end. Each active edge of the data clock captures one pixel word, together with a blanking decision made from the preblank and clamp strobes, and shifts it down a fixed-depth pipeline. The word leaves the pipeline a fixed number of data-clock edges later. On the way out it is optionally replaced by a blanking value, optionally converted to Gray code, and shown either from a final output register or through a transparent path that bypasses that register. A three-state control parks the bus and drops the output-enable flag.

The data clock, preblank strobe and clamp strobe arrive as plain levels sampled on the fast system clock. Polarity bits select which level, or which edge for the data clock, counts as active. Blanking value, Gray coding, output mode and three-state are applied at the output, so changing them takes effect at once. The blanking decision travels down the pipeline with its pixel.

Top module: `pix_out_fmt`

## Requirements
- R1: In latched mode (`out_transp`=0), the pixel captured at active data-clock edge k is shown on `dout` just after active edge k+LAT (LAT defaults to 9). Before LAT+1 edges have been seen since reset, `dout` shows zero.
- R2: With `dclk_pol`=1 a rising `dclk_i` transition seen on `clk` is the active edge; with `dclk_pol`=0 a falling one is. A transition in the other direction leaves `dout` unchanged.
- R3: A pixel captured while the preblank strobe is active and the clamp strobe inactive is shown as all zeros when `blank_to_clamp`=0. The strobe is active high when `pblk_pol`=1 and active low when `pblk_pol`=0.
- R4: When `blank_to_clamp`=1, a blanked pixel is shown as `clamp_lvl`, zero-extended into the low bits of the word.
- R5: When the clamp strobe is active at the capture edge, the pixel is not blanked, whatever the preblank strobe does. The clamp strobe is active high when `clp_pol`=1 and active low when `clp_pol`=0.
- R6: When `gray_en`=1, `dout` carries the Gray code of the word after blanking, bit i equal to bit i XOR bit i+1 of that word, with the top bit unchanged.
- R7: In transparent mode (`out_transp`=1), the word shown is the one that latched mode will show one active edge later, and it is visible in the same `clk` cycle as the edge that captures it into the last stage.
- R8: With `out_hiz`=1, `dout_oe` is 0 and `dout` is all zeros. With `out_hiz`=0, `dout_oe` is 1.
- R9: After reset, every stage holds an unblanked zero, so `dout` is zero in every mode.
- R10: The blanking decision is captured with its pixel and delayed with it. Only the pixels captured while the preblank strobe was active are blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk_i | input | 1 | Data clock level |
| pix_i | input | PIX_W | Converter sample word |
| pblk_i | input | 1 | Preblank strobe level |
| clp_i | input | 1 | Clamp strobe level |
| dclk_pol | input | 1 | 1: rising data-clock edge active, 0: falling |
| pblk_pol | input | 1 | 1: preblank active high, 0: active low |
| clp_pol | input | 1 | 1: clamp strobe active high, 0: active low |
| blank_to_clamp | input | 1 | 1: blank to clamp level, 0: blank to zero |
| clamp_lvl | input | CLP_W | Black level used for blanking |
| gray_en | input | 1 | 1: Gray code output |
| out_transp | input | 1 | 1: transparent output path, 0: registered |
| out_hiz | input | 1 | 1: park the bus, output enable low |
| dout | output | PIX_W | Output data word |
| dout_oe | output | 1 | Output enable for the pad drivers |

## Verification
A counting pixel pattern is pushed through with every data-clock edge recorded in a reference history. This separates an off-by-one latency from a correct one and shows a missing hold between edges. A preblank window that partly overlaps a clamp pulse tells blanking to zero from blanking to the clamp level, and it exposes a clamp strobe that fails to override blanking. The pattern is then repeated with Gray coding, with the transparent path, and with all polarities inverted, where the inactive data-clock transition must leave the output alone. A final pass with the bus parked checks the enable flag.

// File: rtl/pof_pkg.sv
package pof_pkg;

  typedef enum logic {
    OUT_REGISTERED  = 1'b0,
    OUT_TRANSPARENT = 1'b1
  } out_mode_e;

  // Binary to Gray: each bit XORed with its upper neighbour
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray back to binary, running XOR from the top bit down
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Strobe level against its polarity bit
  function automatic logic strobe_active(input logic lvl, input logic pol);
    return lvl ~^ pol;
  endfunction

endpackage

// File: rtl/pof_edge.sv
module pof_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic pol,
  output logic adv
);
  logic lvl_q;

  always_ff @(posedge clk) lvl_q <= lvl;

  assign adv = rst_n && (pol ? (lvl && !lvl_q) : (!lvl && lvl_q));

  AST_ADV_ON_ACTIVE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (lvl == pol) && ($past(lvl) != pol)); // R2

endmodule

// File: rtl/pof_pipe.sv
module pof_pipe #(
  parameter int W     = 12,
  parameter int DEPTH = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] pix_d,
  input  logic         blank_d,
  output logic         head_blank,
  output logic [W:0]   last_q,
  output logic [W:0]   out_q
);
  localparam int SW = W + 1;

  logic [SW-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      out_q <= '0;
    end else if (adv) begin
      stg[0] <= {blank_d, pix_d};
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      out_q <= stg[DEPTH-1];
    end
  end

  assign last_q     = stg[DEPTH-1];
  assign head_blank = stg[0][W];

  AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(out_q) && $stable(last_q)); // R1

endmodule

// File: rtl/pof_fmt.sv
module pof_fmt #(
  parameter int W  = 12,
  parameter int CW = 8
) (
  input  logic          rst_n,
  input  logic [W:0]    word_q,
  input  logic          blank_to_clamp,
  input  logic [CW-1:0] clamp_lvl,
  input  logic          gray_en,
  output logic [W-1:0]  word_o
);
  import pof_pkg::*;

  logic [W-1:0] after_blank;
  logic [31:0]  gray_full;

  always_comb begin
    if (word_q[W]) after_blank = blank_to_clamp ? W'(clamp_lvl) : '0;
    else           after_blank = word_q[W-1:0];
    gray_full = to_gray(32'(after_blank));
    word_o    = gray_en ? gray_full[W-1:0] : after_blank;
  end

  always_comb begin
    if (rst_n && gray_en)
      AST_GRAY_REVERSIBLE: assert (from_gray(32'(word_o)) == 32'(after_blank)); // R6
  end

endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt #(
  parameter int PIX_W = 12,
  parameter int CLP_W = 8,
  parameter int LAT   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dclk_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pblk_i,
  input  logic             clp_i,
  input  logic             dclk_pol,
  input  logic             pblk_pol,
  input  logic             clp_pol,
  input  logic             blank_to_clamp,
  input  logic [CLP_W-1:0] clamp_lvl,
  input  logic             gray_en,
  input  logic             out_transp,
  input  logic             out_hiz,
  output logic [PIX_W-1:0] dout,
  output logic             dout_oe
);
  import pof_pkg::*;

  localparam int SW = PIX_W + 1;

  logic          adv;
  logic          pblk_act;
  logic          clp_act;
  logic          blank_d;
  logic          head_blank;
  logic [SW-1:0] last_q;
  logic [SW-1:0] out_q;
  logic [SW-1:0] shown_q;
  logic [PIX_W-1:0] fmt_word;
  out_mode_e     mode;

  pof_edge i_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (dclk_i),
    .pol   (dclk_pol),
    .adv   (adv)
  );

  assign pblk_act = strobe_active(pblk_i, pblk_pol);
  assign clp_act  = strobe_active(clp_i, clp_pol);
  assign blank_d  = pblk_act && !clp_act;

  pof_pipe #(.W(PIX_W), .DEPTH(LAT)) i_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .pix_d      (pix_i),
    .blank_d    (blank_d),
    .head_blank (head_blank),
    .last_q     (last_q),
    .out_q      (out_q)
  );

  assign mode    = out_mode_e'(out_transp);
  assign shown_q = (mode == OUT_TRANSPARENT) ? last_q : out_q;

  pof_fmt #(.W(PIX_W), .CW(CLP_W)) i_fmt (
    .rst_n          (rst_n),
    .word_q         (shown_q),
    .blank_to_clamp (blank_to_clamp),
    .clamp_lvl      (clamp_lvl),
    .gray_en        (gray_en),
    .word_o         (fmt_word)
  );

  assign dout_oe = !out_hiz;
  assign dout    = out_hiz ? '0 : fmt_word;

  AST_PARKED_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0); // R8

  AST_CLAMP_OVERRIDES_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    adv && clp_act |=> !head_blank); // R5

  AST_PREBLANK_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    adv && pblk_act && !clp_act |=> head_blank); // R10

endmodule

// File: tb/test_pix_out_fmt.sv
module test_pix_out_fmt;
  localparam int PIX_W = 12;
  localparam int CLP_W = 8;
  localparam int LAT   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dclk_i = 1'b0;
  logic [PIX_W-1:0] pix_i = '0;
  logic pblk_i = 1'b0, clp_i = 1'b0;
  logic dclk_pol = 1'b1, pblk_pol = 1'b1, clp_pol = 1'b1;
  logic blank_to_clamp = 1'b0;
  logic [CLP_W-1:0] clamp_lvl = '0;
  logic gray_en = 1'b0, out_transp = 1'b0, out_hiz = 1'b0;
  logic [PIX_W-1:0] dout;
  logic dout_oe;

  always #2 clk = ~clk;

  pix_out_fmt #(.PIX_W(PIX_W), .CLP_W(CLP_W), .LAT(LAT)) i_pix_out_fmt (
    .clk(clk), .rst_n(rst_n), .dclk_i(dclk_i), .pix_i(pix_i),
    .pblk_i(pblk_i), .clp_i(clp_i), .dclk_pol(dclk_pol),
    .pblk_pol(pblk_pol), .clp_pol(clp_pol),
    .blank_to_clamp(blank_to_clamp), .clamp_lvl(clamp_lvl),
    .gray_en(gray_en), .out_transp(out_transp), .out_hiz(out_hiz),
    .dout(dout), .dout_oe(dout_oe)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int n_edges = 0;
  int hpix [0:1023];
  bit hblk [0:1023];
  logic prev_lvl = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_word(input int pix, input bit blk);
    int v;
    int g;
    v = blk ? (blank_to_clamp ? int'(clamp_lvl) : 0) : pix;
    if (!gray_en) return v;
    g = 0;
    for (int i = 0; i < PIX_W; i++) begin
      bit hi;
      hi = (i == PIX_W-1) ? 1'b0 : v[i+1];
      g[i] = v[i] ^ hi;
    end
    return g;
  endfunction

  function automatic int expected_dout();
    int idx;
    if (out_hiz) return 0;
    idx = out_transp ? n_edges - LAT : n_edges - 1 - LAT;
    if (idx < 0) return ref_word(0, 1'b0);
    return ref_word(hpix[idx], hblk[idx]);
  endfunction

  task automatic compare(input string tag);
    int e;
    e = expected_dout();
    check(int'(dout) == e, tag, int'(dout), e);
    check(dout_oe == !out_hiz, "R8", int'(dout_oe), int'(!out_hiz));
  endtask

  task automatic step(input logic lvl, input int pix, input bit pb, input bit cp, input string tag);
    bit act;
    @(negedge clk);
    dclk_i = lvl;
    pix_i  = PIX_W'(pix);
    pblk_i = pb ? pblk_pol : !pblk_pol;
    clp_i  = cp ? clp_pol : !clp_pol;
    act = (lvl != prev_lvl) && (lvl == dclk_pol);
    prev_lvl = lvl;
    @(posedge clk);
    if (act) begin
      hpix[n_edges] = pix & ((1 << PIX_W) - 1);
      hblk[n_edges] = pb && !cp;
      n_edges++;
    end
    #1;
    compare(tag);
  endtask

  task automatic pixel(input int pix, input bit pb, input bit cp, input string tag);
    step(dclk_pol, pix, pb, cp, tag);
    step(!dclk_pol, pix, pb, cp, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_edges, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(dout == '0, "R9", int'(dout), 0);
    check(dout_oe == 1'b1, "R9", int'(dout_oe), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R3 R5 R10: counting pattern, preblank window overlapped by a clamp pulse
    for (int i = 0; i < 30; i++)
      pixel(i * 37 + 5, (i >= 12 && i <= 16), (i == 14 || i == 15), "R1_R3_R5_R10");

    // R4: blank to the programmed black level
    blank_to_clamp = 1'b1;
    clamp_lvl = 8'hA5;
    for (int i = 0; i < 20; i++)
      pixel(4095 - i * 53, (i >= 4 && i <= 8), 1'b0, "R4");

    // R6: Gray coding applied after blanking
    gray_en = 1'b1;
    for (int i = 0; i < 20; i++)
      pixel(i * 211 + 1, (i >= 6 && i <= 9), (i == 9), "R6");

    // R7: transparent path, one edge ahead of the register
    out_transp = 1'b1;
    gray_en = 1'b0;
    for (int i = 0; i < 20; i++)
      pixel(i * 97 + 3, (i == 10), 1'b0, "R7");
    out_transp = 1'b0;

    // R2: inverted polarities; rising data-clock transitions must not advance
    dclk_pol = 1'b0;
    pblk_pol = 1'b0;
    clp_pol  = 1'b0;
    blank_to_clamp = 1'b0;
    step(1'b1, 0, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 20; i++)
      pixel(i * 151 + 7, (i >= 5 && i <= 7), (i == 7), "R2_R3");
    for (int i = 0; i < 4; i++)
      step(1'b1, 99, 1'b0, 1'b0, "R2");

    // R8: parked bus
    out_hiz = 1'b1;
    for (int i = 0; i < 10; i++)
      pixel(i * 300 + 11, 1'b0, 1'b0, "R8");
    out_hiz = 1'b0;
    for (int i = 0; i < 12; i++)
      pixel(i * 17, 1'b0, 1'b0, "R1");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule